// File: doc/BRIEF.md
# Working Register Address Translator

This unit sits between an 8-bit CPU's operand decoder and its register file. It converts each register operand of an instruction into a physical location, given as a page number, an 8-bit offset and an area qualifier. It holds the state that this conversion needs: two slice pointers, a page selector with separate read-side and write-side nibbles, and a bank flag for the banked part of the control-register window. Two independent translation paths, one for the source operand and one for the destination operand, work in the same cycle. An operation can therefore read from one page and write to another.

An operand is given in one of two forms. The first is a short 4-bit working-register field. The second is a full 8-bit register address with an addressing-mode tag: direct, or indirect/indexed. Short fields and escaped 8-bit addresses are resolved through the slice pointers. The top 64 offsets go to the control window or to the stack area, depending on the mode. A pair flag marks 16-bit accesses, which must start at an even offset.

The bank flag is a two-state machine. `BANK_ZERO` is the reset state. It takes the transition `GO_ONE` when the bank-set command is alone. `BANK_ONE` takes the transition `GO_ZERO` when the bank-clear command is alone. Both states `HOLD` when neither command is present or when both are present. The pointers load through a single write port, and a write takes effect on the next clock.

Top module: `wra_translator`

## Requirements
- R1: For a short operand (`*_short`=1), bit 3 of the 4-bit field (`*_val[3]`) picks the pointer: 0 picks slice pointer A, 1 picks slice pointer B. Bits 7:4 of `*_val` are ignored.
- R2: A working-register reference resolves to the offset made of bits 7:3 of the chosen pointer above bits 2:0 of the field. The result is then classified as a direct access.
- R3: A non-short operand in direct mode (`*_mode`=0) whose upper nibble is 1100b is a working-register reference. Its lower nibble resolves as in R1/R2. In indirect mode (`*_mode`=1) the same value is used unchanged as an offset.
- R4: After reset, pointer A holds C0h, pointer B holds C8h, the page selector holds 00h and the bank flag is in `BANK_ZERO`. Short fields 0 to 15 therefore resolve to C0h to CFh.
- R5: An offset below C0h gets area code 0 (paged). Its page is the page selector's bits 3:0 on the source path and bits 7:4 on the destination path.
- R6: A direct-class offset in C0h to DFh gets area code 1 (control, low half) with page 0.
- R7: A direct-class offset in E0h to FFh gets area code 2 in `BANK_ZERO` or code 3 in `BANK_ONE`, with page 0. If both `bank_set` and `bank_clr` are high, the flag keeps its state.
- R8: An indirect-mode, non-escaped offset in C0h to FFh gets area code 4 (stack area), with the path's page from the page selector.
- R9: With `*_pair`=1 and an odd resolved offset, `*_err` is 1 and the output offset has bit 0 cleared. With an even offset, or with `*_pair`=0, `*_err` is 0 and the offset is unchanged.
- R10: When `wr_en`=1, `wr_sel` 0 loads pointer A, 1 loads pointer B, and 2 loads the page selector from `wr_data` at the next clock. A value of 3 changes nothing.
- R11: The source and destination paths resolve independently in the same cycle, each with its own operand, mode and pair inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pointer write strobe |
| wr_sel | input | 2 | Write target: 0 pointer A, 1 pointer B, 2 page selector, 3 none |
| wr_data | input | 8 | Write data |
| bank_set | input | 1 | Command to select bank 1 |
| bank_clr | input | 1 | Command to select bank 0 |
| src_short | input | 1 | Source operand is a 4-bit working field |
| src_val | input | 8 | Source operand value |
| src_mode | input | 1 | Source mode: 0 direct, 1 indirect/indexed |
| src_pair | input | 1 | Source is a 16-bit pair access |
| dst_short | input | 1 | Destination operand is a 4-bit working field |
| dst_val | input | 8 | Destination operand value |
| dst_mode | input | 1 | Destination mode: 0 direct, 1 indirect/indexed |
| dst_pair | input | 1 | Destination is a 16-bit pair access |
| src_page | output | 4 | Source physical page |
| src_off | output | 8 | Source offset |
| src_area | output | 3 | Source area code (0 paged, 1 control low, 2 bank 0, 3 bank 1, 4 stack area) |
| src_err | output | 1 | Source odd pair error |
| dst_page | output | 4 | Destination physical page |
| dst_off | output | 8 | Destination offset |
| dst_area | output | 3 | Destination area code |
| dst_err | output | 1 | Destination odd pair error |

## Verification
The bench targets the escape nibble in both modes. A design that ignored the mode would send indirect C5h into the control window instead of the stack area, and one that ignored the escape would expose C5h as a raw offset. It exercises non-contiguous pointer settings and pointers with nonzero low bits. A design that joined the wrong bit ranges would return offsets that are off by a slice or that carry pointer low bits. It also drives bank set and clear together. A design that gave either command priority would flip the bank. The nibble swap between source and destination pages is covered, as are odd pair offsets landing in the banked window. Wrong nibble order shows up as swapped pages, and a missing bit-0 clear leaves an odd offset flagged as an error.

// File: rtl/wra_pkg.sv
package wra_pkg;

    localparam int OFF_W   = 8;
    localparam int PAGE_W  = 4;
    localparam int SLICE_W = 3;
    localparam int BASE_W  = OFF_W - SLICE_W;
    localparam int NIB_W   = SLICE_W + 1;

    localparam logic [OFF_W-1:0]  PTRA_RST = 8'hC0;
    localparam logic [OFF_W-1:0]  PTRB_RST = 8'hC8;
    localparam logic [OFF_W-1:0]  PAGE_RST = 8'h00;
    localparam logic [NIB_W-1:0]  ESC_NIB  = 4'hC;

    typedef enum logic [2:0] {
        AREA_PAGED = 3'd0,
        AREA_CTRL  = 3'd1,
        AREA_BANK0 = 3'd2,
        AREA_BANK1 = 3'd3,
        AREA_STACK = 3'd4
    } area_e;

    typedef enum logic {
        AM_DIRECT   = 1'b0,
        AM_INDIRECT = 1'b1
    } amode_e;

    typedef enum logic [1:0] {
        WSEL_PTRA = 2'd0,
        WSEL_PTRB = 2'd1,
        WSEL_PAGE = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;

    typedef enum logic {
        BANK_ZERO = 1'b0,
        BANK_ONE  = 1'b1
    } bank_state_e;

endpackage

// File: rtl/wra_bank_fsm.sv
module wra_bank_fsm
    import wra_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bank_set,
    input  logic bank_clr,
    output logic bank_hi
);

    bank_state_e state_q;
    bank_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BANK_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_ZERO: begin
                if (bank_set && !bank_clr) begin
                    state_d = BANK_ONE;
                end
            end
            BANK_ONE: begin
                if (bank_clr && !bank_set) begin
                    state_d = BANK_ZERO;
                end
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            BANK_ZERO: bank_hi = 1'b0;
            BANK_ONE:  bank_hi = 1'b1;
        endcase
    end

endmodule

// File: rtl/wra_ptr_file.sv
module wra_ptr_file
    import wra_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [OFF_W-1:0]  wr_data,
    output logic [BASE_W-1:0] base_a,
    output logic [BASE_W-1:0] base_b,
    output logic [OFF_W-1:0]  page_sel
);

    logic [BASE_W-1:0] base_a_q;
    logic [BASE_W-1:0] base_b_q;
    logic [OFF_W-1:0]  page_q;
    wsel_e             sel;

    assign sel = wsel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_a_q <= PTRA_RST[OFF_W-1:SLICE_W];
            base_b_q <= PTRB_RST[OFF_W-1:SLICE_W];
            page_q   <= PAGE_RST;
        end else if (wr_en) begin
            unique case (sel)
                WSEL_PTRA: base_a_q <= wr_data[OFF_W-1:SLICE_W];
                WSEL_PTRB: base_b_q <= wr_data[OFF_W-1:SLICE_W];
                WSEL_PAGE: page_q   <= wr_data;
                WSEL_NONE: ;
            endcase
        end
    end

    assign base_a   = base_a_q;
    assign base_b   = base_b_q;
    assign page_sel = page_q;

endmodule

// File: rtl/wra_resolve.sv
module wra_resolve
    import wra_pkg::*;
(
    input  logic              is_short,
    input  logic [OFF_W-1:0]  val,
    input  logic              mode,
    input  logic              pair,
    input  logic [BASE_W-1:0] base_a,
    input  logic [BASE_W-1:0] base_b,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              bank_hi,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o,
    output area_e             area_o,
    output logic              err_o
);

    logic              working;
    logic              as_direct;
    logic [NIB_W-1:0]  nib;
    logic [BASE_W-1:0] base_sel;
    logic [OFF_W-1:0]  raw;
    logic              upper_quarter;

    assign nib      = val[NIB_W-1:0];
    assign working  = is_short ||
                      ((amode_e'(mode) == AM_DIRECT) && (val[OFF_W-1:NIB_W] == ESC_NIB));
    assign base_sel = nib[SLICE_W] ? base_b : base_a;
    assign raw      = working ? {base_sel, nib[SLICE_W-1:0]} : val;
    assign as_direct = working || (amode_e'(mode) == AM_DIRECT);
    assign upper_quarter = &raw[OFF_W-1:OFF_W-2];

    always_comb begin
        if (!upper_quarter) begin
            area_o = AREA_PAGED;
        end else if (!as_direct) begin
            area_o = AREA_STACK;
        end else if (!raw[OFF_W-3]) begin
            area_o = AREA_CTRL;
        end else if (bank_hi) begin
            area_o = AREA_BANK1;
        end else begin
            area_o = AREA_BANK0;
        end
    end

    always_comb begin
        unique case (area_o)
            AREA_PAGED, AREA_STACK: page_o = page_in;
            default:                page_o = '0;
        endcase
    end

    assign err_o = pair && raw[0];
    assign off_o = {raw[OFF_W-1:1], raw[0] & ~pair};

endmodule

// File: rtl/wra_translator.sv
module wra_translator
    import wra_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        bank_set,
    input  logic        bank_clr,
    input  logic        src_short,
    input  logic [7:0]  src_val,
    input  logic        src_mode,
    input  logic        src_pair,
    input  logic        dst_short,
    input  logic [7:0]  dst_val,
    input  logic        dst_mode,
    input  logic        dst_pair,
    output logic [3:0]  src_page,
    output logic [7:0]  src_off,
    output logic [2:0]  src_area,
    output logic        src_err,
    output logic [3:0]  dst_page,
    output logic [7:0]  dst_off,
    output logic [2:0]  dst_area,
    output logic        dst_err
);

    localparam int NPATH = 2;

    logic [BASE_W-1:0] base_a;
    logic [BASE_W-1:0] base_b;
    logic [OFF_W-1:0]  page_sel;
    logic              bank_hi;

    logic              p_short [NPATH];
    logic [OFF_W-1:0]  p_val   [NPATH];
    logic              p_mode  [NPATH];
    logic              p_pair  [NPATH];
    logic [PAGE_W-1:0] p_pgin  [NPATH];
    logic [PAGE_W-1:0] p_page  [NPATH];
    logic [OFF_W-1:0]  p_off   [NPATH];
    area_e             p_area  [NPATH];
    logic              p_err   [NPATH];

    wra_ptr_file u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .base_a   (base_a),
        .base_b   (base_b),
        .page_sel (page_sel)
    );

    wra_bank_fsm u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_set (bank_set),
        .bank_clr (bank_clr),
        .bank_hi  (bank_hi)
    );

    // path 0 reads with the low page nibble, path 1 writes with the high one
    assign p_short[0] = src_short;
    assign p_val[0]   = src_val;
    assign p_mode[0]  = src_mode;
    assign p_pair[0]  = src_pair;
    assign p_pgin[0]  = page_sel[PAGE_W-1:0];
    assign p_short[1] = dst_short;
    assign p_val[1]   = dst_val;
    assign p_mode[1]  = dst_mode;
    assign p_pair[1]  = dst_pair;
    assign p_pgin[1]  = page_sel[OFF_W-1:PAGE_W];

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        wra_resolve u_res (
            .is_short (p_short[g]),
            .val      (p_val[g]),
            .mode     (p_mode[g]),
            .pair     (p_pair[g]),
            .base_a   (base_a),
            .base_b   (base_b),
            .page_in  (p_pgin[g]),
            .bank_hi  (bank_hi),
            .page_o   (p_page[g]),
            .off_o    (p_off[g]),
            .area_o   (p_area[g]),
            .err_o    (p_err[g])
        );
    end

    assign src_page = p_page[0];
    assign src_off  = p_off[0];
    assign src_area = p_area[0];
    assign src_err  = p_err[0];
    assign dst_page = p_page[1];
    assign dst_off  = p_off[1];
    assign dst_area = p_area[1];
    assign dst_err  = p_err[1];

endmodule

// File: rtl/wra_translator_chk.sv
module wra_translator_chk
    import wra_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       src_short,
    input logic       src_mode,
    input logic       src_pair,
    input logic       dst_pair,
    input logic [3:0] src_page,
    input logic [7:0] src_off,
    input logic [2:0] src_area,
    input logic       src_err,
    input logic [7:0] dst_off,
    input logic [2:0] dst_area,
    input logic       dst_err
);

    // R6
    ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_area == AREA_CTRL) |-> (src_page == 4'd0 && src_off[7:5] == 3'b110));

    // R7
    bank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_area == AREA_BANK0 || src_area == AREA_BANK1) |->
        (src_off[7:5] == 3'b111 && src_page == 4'd0));

    // R8
    stack_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_area == AREA_STACK) |-> (src_mode && !src_short && src_off[7:6] == 2'b11));

    // R9
    src_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |-> (src_pair && !src_off[0]));

    // R9
    dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_err |-> (dst_pair && !dst_off[0]));

    // R5
    paged_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_area == AREA_PAGED) |-> (dst_off < 8'hC0));

endmodule

bind wra_translator wra_translator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_short (src_short),
    .src_mode  (src_mode),
    .src_pair  (src_pair),
    .dst_pair  (dst_pair),
    .src_page  (src_page),
    .src_off   (src_off),
    .src_area  (src_area),
    .src_err   (src_err),
    .dst_off   (dst_off),
    .dst_area  (dst_area),
    .dst_err   (dst_err)
);

// File: tb/wra_translator_bench.sv
module wra_translator_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       bank_set = 1'b0;
    logic       bank_clr = 1'b0;
    logic       src_short = 1'b0;
    logic [7:0] src_val = 8'd0;
    logic       src_mode = 1'b0;
    logic       src_pair = 1'b0;
    logic       dst_short = 1'b0;
    logic [7:0] dst_val = 8'd0;
    logic       dst_mode = 1'b0;
    logic       dst_pair = 1'b0;
    logic [3:0] src_page;
    logic [7:0] src_off;
    logic [2:0] src_area;
    logic       src_err;
    logic [3:0] dst_page;
    logic [7:0] dst_off;
    logic [2:0] dst_area;
    logic       dst_err;

    int total = 0;
    int bad = 0;

    // reference state
    int m_pa = 192;
    int m_pb = 200;
    int m_pg = 0;
    int m_bank = 0;

    always #10 clk = ~clk;

    wra_translator u_wra_translator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bank_set(bank_set), .bank_clr(bank_clr),
        .src_short(src_short), .src_val(src_val), .src_mode(src_mode), .src_pair(src_pair),
        .dst_short(dst_short), .dst_val(dst_val), .dst_mode(dst_mode), .dst_pair(dst_pair),
        .src_page(src_page), .src_off(src_off), .src_area(src_area), .src_err(src_err),
        .dst_page(dst_page), .dst_off(dst_off), .dst_area(dst_area), .dst_err(dst_err)
    );

    task automatic model(input int sh, input int v, input int md, input int pr, input int side,
                         output int e_page, output int e_off, output int e_area, output int e_err,
                         output string tag);
        int addr;
        int direct;
        int n;
        int p;
        int wk;
        wk = (sh != 0) || (md == 0 && (v / 16) == 12);
        if (wk) begin
            n = v % 16;
            p = (n >= 8) ? m_pb : m_pa;
            addr = (p / 8) * 8 + (n % 8);
            direct = 1;
        end else begin
            addr = v;
            direct = (md == 0);
        end
        if (addr < 192)            e_area = 0;
        else if (!direct)          e_area = 4;
        else if (addr < 224)       e_area = 1;
        else                       e_area = (m_bank != 0) ? 3 : 2;
        if (e_area == 0 || e_area == 4) e_page = (side != 0) ? (m_pg / 16) : (m_pg % 16);
        else                            e_page = 0;
        e_err = (pr != 0 && (addr % 2) == 1) ? 1 : 0;
        e_off = (e_err != 0) ? addr - 1 : addr;
        if (e_err != 0)       tag = "R9";
        else if (e_area == 4) tag = "R8";
        else if (e_area >= 2) tag = "R7";
        else if (e_area == 1) tag = "R6";
        else if (wk)          tag = "R2";
        else                  tag = "R5";
    endtask

    task automatic compare(input string tag, input string side, input int a_pg, input int a_off,
                           input int a_ar, input int a_er, input int e_pg, input int e_off,
                           input int e_ar, input int e_er);
        total++;
        if (a_pg != e_pg || a_off != e_off || a_ar != e_ar || a_er != e_er) begin
            bad++;
            $display("FAIL %s %s: page/off/area/err actual %0d/%02h/%0d/%0d expected %0d/%02h/%0d/%0d",
                     tag, side, a_pg, a_off, a_ar, a_er, e_pg, e_off, e_ar, e_er);
        end
    endtask

    task automatic check_now(input string extra);
        int pg, off, ar, er;
        string tag;
        model(int'(src_short), int'(src_val), int'(src_mode), int'(src_pair), 0, pg, off, ar, er, tag);
        compare({tag, extra}, "src", int'(src_page), int'(src_off), int'(src_area), int'(src_err),
                pg, off, ar, er);
        model(int'(dst_short), int'(dst_val), int'(dst_mode), int'(dst_pair), 1, pg, off, ar, er, tag);
        compare({tag, extra}, "dst", int'(dst_page), int'(dst_off), int'(dst_area), int'(dst_err),
                pg, off, ar, er);
    endtask

    // one clock: drive after the falling edge, check, then advance the model at the rising edge
    task automatic cyc(input logic we, input logic [1:0] ws, input logic [7:0] wd,
                       input logic bs, input logic bc,
                       input logic ssh, input logic [7:0] sv, input logic sm, input logic sp,
                       input logic dsh, input logic [7:0] dv, input logic dm, input logic dp,
                       input string extra);
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd; bank_set = bs; bank_clr = bc;
        src_short = ssh; src_val = sv; src_mode = sm; src_pair = sp;
        dst_short = dsh; dst_val = dv; dst_mode = dm; dst_pair = dp;
        #5;
        check_now(extra);
        @(posedge clk);
        if (we) begin
            case (ws)
                2'd0: m_pa = int'(wd);
                2'd1: m_pb = int'(wd);
                2'd2: m_pg = int'(wd);
                default: ;
            endcase
        end
        if (bs && !bc) m_bank = 1;
        if (bc && !bs) m_bank = 0;
    endtask

    task automatic idle_op(input logic ssh, input logic [7:0] sv, input logic sm, input logic sp,
                           input logic dsh, input logic [7:0] dv, input logic dm, input logic dp,
                           input string extra);
        cyc(1'b0, 2'd0, 8'd0, 1'b0, 1'b0, ssh, sv, sm, sp, dsh, dv, dm, dp, extra);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [7:0] wd, input string extra);
        cyc(1'b1, ws, wd, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, extra);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R1: reset pointers give C0h..CFh
        for (int i = 0; i < 16; i++) begin
            idle_op(1'b1, 8'(i), 1'b0, 1'b0, 1'b1, 8'(15 - i), 1'b1, 1'b0, " R4 R1");
        end

        // R10 R2: load pointers with nonzero low bits, non-contiguous slices
        wr(2'd0, 8'h75, " R10");
        wr(2'd1, 8'h4B, " R10");
        idle_op(1'b1, 8'hF6, 1'b0, 1'b0, 1'b1, 8'h0D, 1'b0, 1'b0, " R2 R1");

        // R10: selector 3 is ignored
        wr(2'd3, 8'h00, " R10");
        idle_op(1'b1, 8'h03, 1'b0, 1'b0, 1'b1, 8'h0B, 1'b0, 1'b0, " R10");

        // R3: escape in direct mode vs indirect mode
        idle_op(1'b0, 8'hC5, 1'b0, 1'b0, 1'b0, 8'hC5, 1'b1, 1'b0, " R3");
        idle_op(1'b0, 8'hCE, 1'b0, 1'b0, 1'b0, 8'hCE, 1'b1, 1'b0, " R3");

        // R5 R11: page nibbles
        wr(2'd2, 8'h31, " R10");
        idle_op(1'b0, 8'h40, 1'b0, 1'b0, 1'b0, 8'hBF, 1'b1, 1'b0, " R5 R11");

        // R6 R8
        idle_op(1'b0, 8'hD0, 1'b0, 1'b0, 1'b0, 8'hD0, 1'b1, 1'b0, " R6 R8");
        idle_op(1'b0, 8'hDF, 1'b1, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0, " R8 R6");

        // R7: bank commands
        idle_op(1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");
        cyc(1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");
        idle_op(1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");
        cyc(1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");
        idle_op(1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7 both");
        cyc(1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");
        idle_op(1'b0, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, " R7");

        // R9: pair alignment
        idle_op(1'b0, 8'h41, 1'b0, 1'b1, 1'b0, 8'h42, 1'b0, 1'b1, " R9");
        idle_op(1'b1, 8'h0F, 1'b0, 1'b1, 1'b0, 8'hE7, 1'b0, 1'b1, " R9");

        // random traffic against the reference model
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            logic [31:0] s;
            r = $urandom;
            s = $urandom;
            cyc(r[0] & r[1], r[3:2], s[7:0], r[4] & r[5], r[6] & r[7],
                r[8] & r[9], s[15:8], r[10], r[11],
                r[12] & r[13], s[23:16], r[14], r[15], " R11");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule